// File: doc/BRIEF.md
# Serial FIFO Trigger Control

This block is the control side of a serial port's transmit and receive FIFOs. The CPU writes a 16-bit control word that selects a receive trigger level, carries a transmit trigger code, holds a separate clear bit for each FIFO and enables an internal loopback path. The data storage and the serial shifters live elsewhere. This block tracks how many entries each FIFO holds, from push and pop strobes, and raises a receive-data-full level once the receive occupancy reaches the selected trigger level.

The receive trigger code maps to a threshold in one of two ways, chosen by the port's mode input: one table for asynchronous operation and one for clocked synchronous operation. A FIFO clear bit is a software control and is kept apart from the register reset. While the bit is set, its FIFO stays empty and ignores pushes. Both the power-on reset and a deep-standby reset input return the control word and all counters to zero.

Top module: `sfifo_trig_ctrl`

## Requirements
- R1: After power-on reset (rst_n low) or a clock edge with stby_rst high, reg_rdata reads 0x0000, both counts read 0 and both overrun outputs read 0.
- R2: On a clock edge with reg_we high, the control word takes reg_wdata, and reg_rdata shows it from that edge on. The fields are: bits 7:6 receive trigger code, bits 5:4 transmit trigger code (also driven on tx_trig_code), bit 2 transmit FIFO clear, bit 1 receive FIFO clear, bit 0 loopback enable.
- R3: Bits 15:8 and bit 3 of reg_rdata always read 0, whatever was written to them.
- R4: With sync_mode = 0, receive trigger codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14 entries. rx_full is high exactly while rx_count is at or above the threshold, so it falls as soon as pops bring the count below it.
- R5: With sync_mode = 1, receive trigger codes 00, 01, 10 and 11 select thresholds of 1, 2, 8 and 14 entries, with the same level behaviour as R4.
- R6: Each FIFO count rises by one on a push and falls by one on a pop. A pop on an empty FIFO is ignored, and a push together with a pop leaves the count unchanged. Each count holds values from 0 to FIFO_DEPTH (16).
- R7: A push on a full FIFO with no pop in the same cycle is not counted and sets that FIFO's overrun output. The overrun output stays high until that FIFO is cleared (R8) or the block is reset (R1).
- R8: From the edge that writes a FIFO clear bit as 1, that FIFO's count and overrun read 0, and pushes are ignored for as long as the bit stays 1. A push in the same cycle as the write that returns the bit to 0 is counted.
- R9: ser_rx_sel equals ser_tx while the loopback bit is 1, and equals ser_rx_ext while the bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stby_rst | input | 1 | Synchronous deep-standby reset, active high |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| sync_mode | input | 1 | 0 = asynchronous, 1 = clocked synchronous |
| rx_push | input | 1 | Receiver stores one entry |
| rx_pop | input | 1 | CPU reads one receive entry |
| tx_push | input | 1 | CPU writes one transmit entry |
| tx_pop | input | 1 | Transmitter takes one entry |
| rx_count | output | 5 | Receive FIFO occupancy |
| tx_count | output | 5 | Transmit FIFO occupancy |
| rx_full | output | 1 | Receive occupancy at or above trigger level |
| rx_overrun | output | 1 | Sticky receive push-while-full indication |
| tx_overrun | output | 1 | Sticky transmit push-while-full indication |
| tx_trig_code | output | 2 | Transmit trigger code field |
| ser_tx | input | 1 | Serial output of the transmitter |
| ser_rx_ext | input | 1 | External serial input pin |
| ser_rx_sel | output | 1 | Serial input delivered to the receiver |

## Verification
Directed sweeps fill the receive FIFO from empty to full under every trigger code in both modes, then drain it. This shows where rx_full rises and falls and separates the two threshold tables at code 01. Pushes at full, with and without a pop in the same cycle, separate a real overrun from a balanced transfer. Clear-bit writes combined with pushes show that pushes are blocked while the bit is set and counted again once it is cleared. A long seeded random run mixes pushes, pops, writes with random data, mode changes and serial levels, which shows that reserved bits read 0 and that the loopback selection follows the control bit.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int CTRL_W = 16;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } mode_e;

    typedef struct packed {
        logic [1:0] rx_trig;
        logic [1:0] tx_trig;
        logic       tx_clr;
        logic       rx_clr;
        logic       loop_en;
    } ctrl_t;

    // Receive threshold for a trigger code; code 01 differs between modes.
    function automatic int rx_thresh(input logic [1:0] code, input mode_e mode);
        int thr;
        case (code)
            2'b00:   thr = 1;
            2'b01:   thr = (mode == MODE_SYNC) ? 2 : 4;
            2'b10:   thr = 8;
            default: thr = 14;
        endcase
        return thr;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.rx_trig = w[7:6];
        c.tx_trig = w[5:4];
        c.tx_clr  = w[2];
        c.rx_clr  = w[1];
        c.loop_en = w[0];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w      = '0;
        w[7:6] = c.rx_trig;
        w[5:4] = c.tx_trig;
        w[2]   = c.tx_clr;
        w[1]   = c.rx_clr;
        w[0]   = c.loop_en;
        return w;
    endfunction

endpackage

// File: rtl/sfifo_ctrl_reg.sv
module sfifo_ctrl_reg
    import sfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic [1:0]        rx_trig,
    output logic [1:0]        tx_trig,
    output logic              loop_en,
    output logic              rx_clr_d,
    output logic              tx_clr_d
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (stby_rst) begin
            ctrl_d = '0;
        end else if (we) begin
            ctrl_d = ctrl_unpack(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign rdata    = ctrl_pack(ctrl_q);
    assign rx_trig  = ctrl_q.rx_trig;
    assign tx_trig  = ctrl_q.tx_trig;
    assign loop_en  = ctrl_q.loop_en;
    // Clear bits act from the edge that writes them.
    assign rx_clr_d = ctrl_d.rx_clr;
    assign tx_clr_d = ctrl_d.tx_clr;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[15:8], wdata[3]};

    // R2: a written loopback bit is visible after the write edge
    p_write_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !stby_rst) |=> (loop_en == $past(wdata[0])));

    // R1: standby reset empties the control word
    p_stby_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stby_rst |=> (rdata == '0));

endmodule

// File: rtl/sfifo_occ_cnt.sv
module sfifo_occ_cnt #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic          overrun
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovr;
    } occ_t;

    occ_t occ_d, occ_q;
    logic pop_ok, push_ok;

    always_comb begin
        occ_d   = occ_q;
        pop_ok  = pop && (occ_q.cnt != '0);
        push_ok = push && ((occ_q.cnt != FULL) || pop_ok);
        if (stby_rst || clr) begin
            occ_d = '0;
        end else begin
            occ_d.cnt = occ_q.cnt + CW'(push_ok) - CW'(pop_ok);
            if (push && !push_ok) occ_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign count   = occ_q.cnt;
    assign overrun = occ_q.ovr;

    // R6: occupancy never exceeds the depth
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    // R6: popping an empty FIFO leaves it empty
    p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push) |=> (count == '0));

    // R7: push into a full FIFO without a pop flags overrun
    p_ovr_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL && push && !pop && !clr && !stby_rst) |=> (overrun && count == FULL));

    // R8: a clear empties the FIFO
    p_clr_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !overrun));

endmodule

// File: rtl/sfifo_rx_flag.sv
module sfifo_rx_flag
    import sfifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    code,
    input  mode_e         mode,
    output logic          rdf
);

    int thr;

    always_comb begin
        thr = rx_thresh(code, mode);
        rdf = (int'(count) >= thr);
    end

endmodule

// File: rtl/sfifo_trig_ctrl.sv
module sfifo_trig_ctrl
    import sfifo_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_rst,
    input  logic          reg_we,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          sync_mode,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          tx_pop,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_count,
    output logic          rx_full,
    output logic          rx_overrun,
    output logic          tx_overrun,
    output logic [1:0]    tx_trig_code,
    input  logic          ser_tx,
    input  logic          ser_rx_ext,
    output logic          ser_rx_sel
);

    localparam int NFIFO = 2;   // index 0 transmit, 1 receive

    logic [1:0] rx_trig;
    logic       loop_en, rx_clr, tx_clr;

    logic [NFIFO-1:0] f_push, f_pop, f_clr, f_ovr;
    logic [CW-1:0]    f_cnt [NFIFO];

    sfifo_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .stby_rst (stby_rst),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .rx_trig  (rx_trig),
        .tx_trig  (tx_trig_code),
        .loop_en  (loop_en),
        .rx_clr_d (rx_clr),
        .tx_clr_d (tx_clr)
    );

    assign f_push = {rx_push, tx_push};
    assign f_pop  = {rx_pop,  tx_pop};
    assign f_clr  = {rx_clr,  tx_clr};

    for (genvar g = 0; g < NFIFO; g++) begin : g_fifo
        sfifo_occ_cnt #(
            .DEPTH (FIFO_DEPTH),
            .CW    (CW)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .stby_rst (stby_rst),
            .clr      (f_clr[g]),
            .push     (f_push[g]),
            .pop      (f_pop[g]),
            .count    (f_cnt[g]),
            .overrun  (f_ovr[g])
        );
    end

    assign tx_count   = f_cnt[0];
    assign rx_count   = f_cnt[1];
    assign tx_overrun = f_ovr[0];
    assign rx_overrun = f_ovr[1];

    sfifo_rx_flag #(.CW(CW)) u_flag (
        .count (rx_count),
        .code  (rx_trig),
        .mode  (mode_e'(sync_mode)),
        .rdf   (rx_full)
    );

    assign ser_rx_sel = loop_en ? ser_tx : ser_rx_ext;

    // R4: an empty receive FIFO never reports full
    p_rdf_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_full);

    // R5: at the top threshold the flag is up in either mode
    p_rdf_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= CW'(14)) |-> rx_full);

    // R3: reserved read bits stay low across writes
    p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata[15:8] == 8'h00 && !reg_rdata[3]));

endmodule

// File: tb/sfifo_trig_ctrl_bench.sv
module sfifo_trig_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby_rst = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sync_mode = 1'b0;
    logic        rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [4:0]  rx_count, tx_count;
    logic        rx_full, rx_overrun, tx_overrun;
    logic [1:0]  tx_trig_code;
    logic        ser_tx = 1'b0, ser_rx_ext = 1'b0;
    logic        ser_rx_sel;

    int nvec = 0;
    int nerr = 0;

    // reference state
    logic [15:0] m_ctrl = '0;
    int          m_cnt [2];
    logic        m_ovr [2];

    always #2 clk = ~clk;

    sfifo_trig_ctrl u_sfifo_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .stby_rst(stby_rst),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sync_mode(sync_mode),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_full(rx_full), .rx_overrun(rx_overrun), .tx_overrun(tx_overrun),
        .tx_trig_code(tx_trig_code),
        .ser_tx(ser_tx), .ser_rx_ext(ser_rx_ext), .ser_rx_sel(ser_rx_sel)
    );

    function automatic int exp_thr(input logic [1:0] code, input logic smode);
        if (code == 2'b00) return 1;
        if (code == 2'b10) return 8;
        if (code == 2'b11) return 14;
        return smode ? 2 : 4;
    endfunction

    task automatic chk(input string what, input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("reg_rdata", "R2", int'(reg_rdata), int'(m_ctrl));
        chk("reserved bits", "R3", int'({reg_rdata[15:8], reg_rdata[3]}), 0);
        chk("tx_trig_code", "R2", int'(tx_trig_code), int'(m_ctrl[5:4]));
        chk("rx_count", "R6", int'(rx_count), m_cnt[1]);
        chk("tx_count", "R6", int'(tx_count), m_cnt[0]);
        chk("rx_overrun", "R7", int'(rx_overrun), int'(m_ovr[1]));
        chk("tx_overrun", "R7", int'(tx_overrun), int'(m_ovr[0]));
        chk("rx_full", sync_mode ? "R5" : "R4", int'(rx_full),
            int'(m_cnt[1] >= exp_thr(m_ctrl[7:6], sync_mode)));
        chk("ser_rx_sel", "R9", int'(ser_rx_sel), int'(m_ctrl[0] ? ser_tx : ser_rx_ext));
    endtask

    // Reference update for one edge, index 0 transmit (clear bit 2), 1 receive (bit 1)
    task automatic model_edge();
        logic p [2];
        logic q [2];
        p[0] = tx_push; p[1] = rx_push;
        q[0] = tx_pop;  q[1] = rx_pop;
        if (stby_rst) begin
            m_ctrl = '0;
            for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_ovr[i] = 1'b0; end
        end else begin
            if (reg_we) m_ctrl = reg_wdata & 16'h00F7;
            for (int i = 0; i < 2; i++) begin
                if (m_ctrl[2 - i]) begin
                    m_cnt[i] = 0; m_ovr[i] = 1'b0;
                end else begin
                    bit pok, uok;
                    pok = q[i] && (m_cnt[i] > 0);
                    uok = p[i] && ((m_cnt[i] < 16) || pok);
                    if (p[i] && !uok) m_ovr[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + int'(uok) - int'(pok);
                end
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
        reg_we = 1'b0; stby_rst = 1'b0;
        rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        reg_we = 1'b1; reg_wdata = d;
        tick();
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt[0] = 0; m_cnt[1] = 0; m_ovr[0] = 1'b0; m_ovr[1] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: power-on reset state
        chk("reset rdata", "R1", int'(reg_rdata), 0);
        chk("reset rx_count", "R1", int'(rx_count), 0);
        chk("reset overrun", "R1", int'({rx_overrun, tx_overrun}), 0);
        check_all();

        // R3: reserved bits ignore all-ones write (clear bits set here too)
        wr(16'hFFFF);
        chk("masked write", "R3", int'(reg_rdata), 16'h00F7);
        wr(16'h0000);

        // R4 / R5: sweep every code in both modes, fill then drain
        for (int md = 0; md < 2; md++) begin
            sync_mode = md[0];
            for (int cd = 0; cd < 4; cd++) begin
                wr({8'h00, cd[1:0], 6'b000000});
                for (int k = 0; k < 16; k++) begin rx_push = 1'b1; tick(); end
                for (int k = 0; k < 16; k++) begin rx_pop = 1'b1; tick(); end
            end
        end

        // R7: fill transmit and receive, push at full with and without pop
        for (int k = 0; k < 16; k++) begin rx_push = 1'b1; tx_push = 1'b1; tick(); end
        rx_push = 1'b1; rx_pop = 1'b1; tick();
        chk("push+pop at full", "R7", int'(rx_overrun), 0);
        rx_push = 1'b1; tx_push = 1'b1; tick();
        chk("overrun after push at full", "R7", int'(rx_overrun && tx_overrun), 1);
        tick();
        chk("overrun sticky", "R7", int'(rx_overrun), 1);

        // R8: receive clear, pushes blocked, release accepts a push
        wr(16'h0002);
        chk("rx clear count", "R8", int'(rx_count), 0);
        chk("tx untouched by rx clear", "R8", int'(tx_count), 16);
        rx_push = 1'b1; tick();
        chk("push blocked while clear", "R8", int'(rx_count), 0);
        rx_push = 1'b1; reg_we = 1'b1; reg_wdata = 16'h0000; tick();
        chk("push on release", "R8", int'(rx_count), 1);
        wr(16'h0004);
        chk("tx clear", "R8", int'({tx_count, tx_overrun}), 0);
        wr(16'h0000);

        // R9: loopback both ways
        wr(16'h0001);
        ser_tx = 1'b1; ser_rx_ext = 1'b0; tick();
        chk("loop selects tx", "R9", int'(ser_rx_sel), 1);
        wr(16'h0000);
        chk("ext selected", "R9", int'(ser_rx_sel), 0);

        // R1: standby reset
        wr(16'h00F1);
        rx_push = 1'b1; tick();
        stby_rst = 1'b1; tick();
        chk("standby rdata", "R1", int'(reg_rdata), 0);
        chk("standby rx_count", "R1", int'(rx_count), 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] d;
            d = 16'($urandom);
            if (($urandom % 4) != 0) d[2:1] = 2'b00;
            reg_we    = (($urandom % 24) == 0);
            reg_wdata = d;
            stby_rst  = (($urandom % 500) == 0);
            if (($urandom % 64) == 0) sync_mode = ~sync_mode;
            rx_push   = (($urandom % 8) < 4);
            rx_pop    = (($urandom % 8) < 3);
            tx_push   = (($urandom % 8) < 3);
            tx_pop    = (($urandom % 8) < 4);
            ser_tx    = 1'($urandom);
            ser_rx_ext = 1'($urandom);
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule